// File: doc/BRIEF.md
# Extended-Reach Mode Host Sequencer

This block is a host-side controller for a serial-video cable equalizer. The equalizer has a mode that gives more reach at the top data rate. That mode may be switched on only while the equalizer is held asleep, and it has to be switched off again once the link is lost. The sequencer talks to the equalizer's 8-bit registers through a single-outstanding request/response port. An SPI master, which is not part of this block, sits behind that port. At a programmable interval the sequencer reads the general control register (address 0x00). Bit 7 of that register is the carrier flag, bits 6 and 5 are mute and bypass, bits 4:3 are the sleep field and bit 2 is the extended-reach bit. When the sequencer is in normal mode and the carrier is present, it also reads the cable-length register (address 0x03), whose bits 7:3 hold a 5-bit length code.

When a carrier is present and the length code is strictly below a programmable threshold, the sequencer runs the entry sequence: force sleep, set the extended-reach bit, wait at least one millisecond, then release sleep to the configured final setting. While the sequencer is in extended mode it reads only register 0x00. A carrier loss there starts the mirror-image exit sequence. An error response on any transfer sends the sequencer into that same exit sequence, beginning with a forced-sleep write, so the part falls back to normal mode. Every write is a read-modify-write: mute and bypass are carried over from the last good read, and bits 7 and 1:0 are written as zero.

Top module: `ext_reach_seq`

## Requirements
- R1: After reset `ext_mode_o`, `busy_o` and `req_valid_o` are all 0.
- R2: The sequencer polls by reading address 0x00. Address 0x03 is read only in normal mode and only after a 0x00 read that returned bit 7 = 1. Every write targets address 0x00.
- R3: Entry starts only when the carrier bit is 1 and the length code (bits 7:3 of 0x03) is strictly below the threshold. A code equal to the threshold, or a missing carrier, causes no write.
- R4: The entry sequence is three writes to 0x00. The first has sleep field = 2'b10 and ext bit = 0. The second has sleep field = 2'b10 and ext bit = 1. The third has the final sleep field and ext bit = 1.
- R5: At least CYC_PER_MS clock cycles pass between the response to the second write of a sequence and the issue of the third write.
- R6: With `final_auto_i` = 1 the final sleep field is 2'b01; with `final_auto_i` = 0 it is 2'b00.
- R7: Written data bits 6:5 equal bits 6:5 of the last error-free read of 0x00. Bits 7 and 1:0 are written as 0.
- R8: In extended mode a 0x00 read with bit 7 = 0 starts the exit sequence: sleep 10 with ext 1, then sleep 10 with ext 0, the wait, then the final sleep field with ext 0. In extended mode with carrier present, no write and no 0x03 read occur. `ext_mode_o` changes only in the cycle after an error-free write response, and it takes that write's bit 2.
- R9: `thr_i` and `final_auto_i` are sampled only while the sequencer is idle in normal mode. A change during a sequence or during extended mode does not affect the writes.
- R10: After an error response, the next accepted request is a forced-sleep write (sleep field 2'b10) to 0x00. The exit sequence follows, ending with `ext_mode_o` = 0.
- R11: `busy_o` rises together with the first write request of a sequence and stays high until the final write has been answered.
- R12: While `req_valid_o` is high and `req_ready_i` is low, the request and its address, data and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_i | input | 5 | Length-code threshold for entry |
| final_auto_i | input | 1 | 1: final sleep field 01, 0: final sleep field 00 |
| req_valid_o | output | 1 | Register access request |
| req_ready_i | input | 1 | Request accepted by SPI master |
| req_write_o | output | 1 | 1 write, 0 read |
| req_addr_o | output | 7 | Register address |
| req_wdata_o | output | 8 | Write data |
| rsp_valid_i | input | 1 | Transfer finished |
| rsp_error_i | input | 1 | Transfer failed (with rsp_valid_i) |
| rsp_rdata_i | input | 8 | Read data (with rsp_valid_i) |
| ext_mode_o | output | 1 | Extended-reach bit as last written successfully |
| busy_o | output | 1 | Mode-change sequence in progress |

## Verification
The bench models the remote registers and logs every write with its cycle, then walks the threshold boundary. A design that compared with "less or equal" would enter at a length code equal to the threshold; one that skipped the carrier test would read the length register or write with no carrier. It checks that the settle wait is measured from the response to the ext-bit write. A counter started at the request, or one cut short by a cycle, would issue the release write too early. It changes the final-sleep input and the mute/bypass bits mid-stream: a design that sampled the input live or kept stale mute/bypass bits would write wrong data. It injects an error response and stalls the request port. A design that ignored errors, or dropped and altered a stalled request, would be seen at the write log.

// File: rtl/ext_reach_seq.sv
module ext_reach_seq #(
  parameter int CYC_PER_MS = 125000,
  parameter int POLL_CYC   = 1024,
  parameter logic [4:0] THR_RESET = 5'b10010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] thr_i,
  input  logic       final_auto_i,
  output logic       req_valid_o,
  input  logic       req_ready_i,
  output logic       req_write_o,
  output logic [6:0] req_addr_o,
  output logic [7:0] req_wdata_o,
  input  logic       rsp_valid_i,
  input  logic       rsp_error_i,
  input  logic [7:0] rsp_rdata_i,
  output logic       ext_mode_o,
  output logic       busy_o
);
  localparam int MAXC = (CYC_PER_MS > POLL_CYC) ? CYC_PER_MS : POLL_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [6:0] A_CTRL = 7'h00;
  localparam logic [6:0] A_LEN  = 7'h03;

  typedef enum logic [2:0] {S_IDLE, S_RD_GEN, S_RD_LEN, S_W_SLP, S_W_EXT, S_WAIT, S_W_FIN} st_t;

  st_t         st;
  logic        pend;
  logic [CW-1:0] cnt;
  logic [1:0]  mb_q;
  logic        tgt, ext_q, fin_q;
  logic [4:0]  thr_q;

  wire is_op   = (st == S_RD_GEN) || (st == S_RD_LEN) || (st == S_W_SLP) || (st == S_W_EXT) || (st == S_W_FIN);
  wire is_wr   = (st == S_W_SLP) || (st == S_W_EXT) || (st == S_W_FIN);
  wire done    = pend && rsp_valid_i;
  wire [1:0] slp = (st == S_W_FIN) ? {1'b0, fin_q} : 2'b10;
  wire ext_bit = (st == S_W_SLP) ? ext_q : tgt;
  wire short_cable = (rsp_rdata_i >> 3) < {3'b000, thr_q};

  assign req_valid_o = is_op && !pend;
  assign req_write_o = is_wr;
  assign req_addr_o  = (st == S_RD_LEN) ? A_LEN : A_CTRL;
  assign req_wdata_o = {1'b0, mb_q, slp, ext_bit, 2'b00};
  assign ext_mode_o  = ext_q;
  assign busy_o      = is_wr || (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pend  <= 1'b0;
      cnt   <= CW'(POLL_CYC - 1);
      mb_q  <= 2'b00;
      tgt   <= 1'b0;
      ext_q <= 1'b0;
      fin_q <= 1'b1;
      thr_q <= THR_RESET;
    end else begin
      if (req_valid_o && req_ready_i) pend <= 1'b1;
      if (st == S_IDLE && !ext_q) begin
        thr_q <= thr_i;
        fin_q <= final_auto_i;
      end
      if (done) begin
        pend <= 1'b0;
        if (rsp_error_i) begin
          tgt <= 1'b0;
          st  <= S_W_SLP;
        end else begin
          case (st)
            S_RD_GEN: begin
              mb_q <= rsp_rdata_i[6:5];
              if (ext_q && !rsp_rdata_i[7]) begin
                tgt <= 1'b0;
                st  <= S_W_SLP;
              end else if (!ext_q && rsp_rdata_i[7]) begin
                st <= S_RD_LEN;
              end else begin
                st  <= S_IDLE;
                cnt <= CW'(POLL_CYC - 1);
              end
            end
            S_RD_LEN: begin
              if (short_cable) begin
                tgt <= 1'b1;
                st  <= S_W_SLP;
              end else begin
                st  <= S_IDLE;
                cnt <= CW'(POLL_CYC - 1);
              end
            end
            S_W_SLP: st <= S_W_EXT;
            S_W_EXT: begin
              ext_q <= tgt;
              st    <= S_WAIT;
              cnt   <= CW'(CYC_PER_MS - 1);
            end
            S_W_FIN: begin
              ext_q <= tgt;
              st    <= S_IDLE;
              cnt   <= CW'(POLL_CYC - 1);
            end
            default: st <= S_IDLE;
          endcase
        end
      end else begin
        case (st)
          S_IDLE: if (cnt == '0) st <= S_RD_GEN; else cnt <= cnt - 1'b1;
          S_WAIT: if (cnt == '0) st <= S_W_FIN;  else cnt <= cnt - 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ext_reach_seq_chk.sv
module ext_reach_seq_chk #(
  parameter int CYC_PER_MS = 125000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid_o,
  input logic       req_ready_i,
  input logic       req_write_o,
  input logic [6:0] req_addr_o,
  input logic [7:0] req_wdata_o,
  input logic       rsp_valid_i,
  input logic       rsp_error_i,
  input logic       ext_mode_o,
  input logic       busy_o
);
  wire acc = req_valid_o && req_ready_i;
  logic        last_slp;
  logic        err_seen;
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_slp <= 1'b0;
      err_seen <= 1'b0;
      gap      <= '1;
    end else begin
      if (acc) last_slp <= req_write_o && (req_wdata_o[4:3] == 2'b10);
      if (rsp_valid_i && rsp_error_i) err_seen <= 1'b1;
      else if (acc) err_seen <= 1'b0;
      if (rsp_valid_i && last_slp) gap <= '0;
      else if (gap != '1) gap <= gap + 1'b1;
    end
  end

  p_wr_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write_o |-> req_addr_o == 7'h00);
  p_rd_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write_o |-> (req_addr_o == 7'h00 || req_addr_o == 7'h03));
  p_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write_o && req_wdata_o[4:3] != 2'b10 |-> gap >= 32'(CYC_PER_MS));
  p_resv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write_o |-> (req_wdata_o[7] == 1'b0 && req_wdata_o[1:0] == 2'b00));
  p_mode_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext_mode_o) |-> $past(rsp_valid_i && !rsp_error_i));
  p_err_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && err_seen |-> (req_write_o && req_wdata_o[4:3] == 2'b10));
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (req_valid_o && req_write_o && req_wdata_o[4:3] == 2'b10));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_wdata_o) && $stable(req_write_o));
endmodule

bind ext_reach_seq ext_reach_seq_chk #(.CYC_PER_MS(CYC_PER_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
  .req_write_o(req_write_o), .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
  .rsp_valid_i(rsp_valid_i), .rsp_error_i(rsp_error_i), .ext_mode_o(ext_mode_o),
  .busy_o(busy_o)
);

// File: tb/sim_ext_reach_seq.sv
`timescale 1ns/1ps
module sim_ext_reach_seq;
  localparam int CPM  = 40;
  localparam int POLL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] thr = 5'b10010;
  logic fin_auto = 1'b1;
  logic rdy = 1'b1;
  logic rsp_v = 1'b0, rsp_e = 1'b0;
  logic [7:0] rsp_d = 8'h00;
  logic req_v, req_w, ext_m, busy;
  logic [6:0] req_a;
  logic [7:0] req_d;

  always #4 clk = ~clk;

  ext_reach_seq #(.CYC_PER_MS(CPM), .POLL_CYC(POLL)) u0 (
    .clk(clk), .rst_n(rst_n), .thr_i(thr), .final_auto_i(fin_auto),
    .req_valid_o(req_v), .req_ready_i(rdy), .req_write_o(req_w),
    .req_addr_o(req_a), .req_wdata_o(req_d), .rsp_valid_i(rsp_v),
    .rsp_error_i(rsp_e), .rsp_rdata_i(rsp_d), .ext_mode_o(ext_m), .busy_o(busy));

  // remote register model
  logic carrier = 1'b0, mute = 1'b0, byp = 1'b0;
  logic [4:0] cli = 5'd0;
  logic [1:0] r_slp = 2'b01;
  logic r_ext = 1'b0;
  logic err_arm = 1'b0;
  int cyc = 0, pcnt = 0, p_wr = 0, p_idx = 0, p_addr = 0;
  int wcnt = 0, rd0 = 0, rd3 = 0;
  logic [7:0] wlog [0:63];
  int wtime [0:63];
  int wrsp [0:63];
  int checks = 0, fails = 0;
  bit finished = 0;

  always @(negedge clk) begin
    cyc++;
    rsp_v = 1'b0;
    rsp_e = 1'b0;
    if (pcnt == 1) begin
      rsp_v = 1'b1;
      rsp_e = err_arm;
      err_arm = 1'b0;
      if (p_wr != 0) begin
        wrsp[p_idx] = cyc;
        rsp_d = 8'h00;
      end else if (p_addr == 3) rsp_d = {cli, 3'b000};
      else rsp_d = {carrier, mute, byp, r_slp, r_ext, 2'b00};
      pcnt = 0;
    end else if (pcnt > 1) pcnt--;
    if (req_v && rdy && rst_n) begin
      p_wr = req_w ? 1 : 0;
      p_addr = int'(req_a);
      if (req_w) begin
        if (wcnt < 64) begin
          wlog[wcnt] = req_d;
          wtime[wcnt] = cyc;
          p_idx = wcnt;
          wcnt++;
        end
        r_slp = req_d[4:3];
        r_ext = req_d[2];
      end else if (req_a == 7'h03) rd3++;
      else rd0++;
      pcnt = 3;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_settled(input logic exp);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (ext_m == exp && !busy) break;
    end
  endtask

  task automatic check_seq(input int base, input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] c, input string tag);
    chk(wcnt - base == 3, {tag, " write count"}, wcnt - base, 3);
    if (wcnt - base >= 3) begin
      chk(wlog[base] == a, {tag, " first write"}, wlog[base], a);
      chk(wlog[base+1] == b, {tag, " second write"}, wlog[base+1], b);
      chk(wlog[base+2] == c, {tag, " third write"}, wlog[base+2], c);
      chk(wtime[base+2] - wrsp[base+1] >= CPM, "R5 settle gap", wtime[base+2] - wrsp[base+1], CPM);
    end
  endtask

  task automatic t_reset;
    chk(ext_m == 1'b0, "R1 ext_mode after reset", ext_m, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(req_v == 1'b0, "R1 req_valid after reset", req_v, 0);
  endtask

  task automatic t_no_carrier;
    int b = wcnt, r0 = rd0, r3 = rd3;
    carrier = 1'b0; cli = 5'd0;
    cycles(120);
    chk(rd0 > r0, "R2 polls register 0x00", rd0 - r0, 1);
    chk(rd3 == r3, "R2 no length read without carrier", rd3 - r3, 0);
    chk(wcnt == b, "R3 no write without carrier", wcnt - b, 0);
  endtask

  task automatic t_equal_threshold;
    int b = wcnt, r3 = rd3;
    mute = 1'b1; byp = 1'b0; cli = 5'd18; carrier = 1'b1;
    cycles(120);
    chk(rd3 > r3, "R2 length read with carrier", rd3 - r3, 1);
    chk(wcnt == b, "R3 no entry at length equal to threshold", wcnt - b, 0);
    chk(ext_m == 1'b0, "R3 still normal", ext_m, 0);
  endtask

  task automatic t_entry;
    int b = wcnt;
    cli = 5'd17;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (busy) break;
    end
    chk(busy == 1'b1, "R11 busy during entry", busy, 1);
    fin_auto = 1'b0;
    wait_settled(1'b1);
    chk(ext_m == 1'b1, "R4 ext_mode after entry", ext_m, 1);
    check_seq(b, 8'h50, 8'h54, 8'h4C, "R4 R6 R9 entry");
  endtask

  task automatic t_hold_ext;
    int b = wcnt, r3 = rd3;
    cycles(80);
    chk(wcnt == b && rd3 == r3, "R8 extended mode quiet while carrier present", (wcnt - b) + (rd3 - r3), 0);
    chk(ext_m == 1'b1, "R8 stays extended", ext_m, 1);
  endtask

  task automatic t_exit;
    int b;
    mute = 1'b0; byp = 1'b1;
    cycles(40);
    b = wcnt;
    carrier = 1'b0;
    wait_settled(1'b0);
    chk(ext_m == 1'b0, "R8 ext_mode after exit", ext_m, 0);
    check_seq(b, 8'h34, 8'h30, 8'h28, "R7 R8 R9 exit");
  endtask

  task automatic t_final_off;
    int b = wcnt;
    cli = 5'd0; carrier = 1'b1;
    wait_settled(1'b1);
    check_seq(b, 8'h30, 8'h34, 8'h24, "R6 entry final 00");
  endtask

  task automatic t_error;
    int b = wcnt;
    cli = 5'd20;
    cycles(4);
    err_arm = 1'b1;
    wait_settled(1'b0);
    check_seq(b, 8'h34, 8'h30, 8'h20, "R10 error recovery");
    cycles(60);
    chk(ext_m == 1'b0 && wcnt == b + 3, "R10 stays normal after recovery", ext_m, 0);
  endtask

  task automatic t_stall;
    int b = wcnt, r0 = rd0, bad = 0;
    logic [6:0] a0;
    rdy = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (req_v) break;
    end
    a0 = req_a;
    chk(req_v == 1'b1, "R12 request raised under stall", req_v, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!req_v || req_a != a0) bad++;
    end
    chk(bad == 0, "R12 request held while not ready", bad, 0);
    chk(rd0 == r0 && wcnt == b, "R12 nothing accepted while not ready", rd0 - r0, 0);
    rdy = 1'b1;
    cycles(30);
    chk(rd0 > r0, "R12 accepted after ready", rd0 - r0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cycles(5);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_carrier();
    t_equal_threshold();
    t_entry();
    t_hold_ext();
    t_exit();
    t_final_off();
    t_error();
    t_stall();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule